// File: doc/BRIEF.md
# External Bus Hold Master

This block lets a graphics engine borrow a shared host bus whenever one of its internal accesses targets memory that lies outside its own local graphics memory. Local graphics memory occupies the address range from zero up to a configurable upper limit. Any request whose 22-bit address is above that limit must go to the shared bus. For such a request the block runs a hold request / hold acknowledge handshake with the external bus owner. It then signals ownership, times the access, and strobes completion back to the requester.

The requester raises `acc_valid` with `acc_addr` and keeps both steady until it sees `acc_done`. In the completion cycle it may present the next address at once. If that address is also external, the bus is kept without a new handshake. The acknowledge can be taken as already synchronous, or it can pass through an internal two-flop synchronizer; a mode input selects which. If the bus owner withdraws the acknowledge in the middle of an access, the block gives the bus up at once. The interrupted access stays pending and is asked for again.

Top module: `hold_bus_master`

## Requirements
- R1: After reset, `bus_hreq`, `bus_men`, `bus_owned` and `acc_done` are all low.
- R2: A request whose address is less than or equal to `gfx_top` (the limit value itself counts as local) never raises `bus_hreq` or `acc_done`.
- R3: A request whose address is greater than `gfx_top` raises `bus_hreq` on the first clock edge after the request is presented. `bus_men` stays low until the acknowledge is seen.
- R4: With `ack_async` low, `hold_ack` is used directly. `bus_men` and `bus_owned` go high on the first clock edge at which `hold_ack` is sampled high while the request is pending.
- R5: With `ack_async` high, `hold_ack` passes through a two-flop synchronizer. `bus_men` goes high on the third clock edge after `hold_ack` rises, and not before.
- R6: `bus_men` is never high while `bus_hreq` is low. When ownership ends, both drop on the same clock edge.
- R7: `acc_done` is a single-cycle pulse. It comes in the ACC_CYCLES-th cycle of ownership of an access (ACC_CYCLES defaults to 4), and only while `bus_men` is high.
- R8: If the requester presents another external address in the completion cycle, `bus_hreq` stays high without a gap, and the next access completes as well.
- R9: If no external request is pending after completion, `bus_hreq` and `bus_men` drop on the second clock edge after the completion cycle.
- R10: If the synchronized acknowledge is low while the block owns the bus, `bus_hreq` and `bus_men` drop on the next clock edge. The interrupted access gives no `acc_done`.
- R11: After such a withdrawal, once the acknowledge has been seen low, the still-pending access raises `bus_hreq` again. When the acknowledge returns, that access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Internal access request, held until `acc_done` |
| acc_addr | input | 22 | Address of the requested access |
| gfx_top | input | 22 | Highest address of local graphics memory |
| ack_async | input | 1 | 1: acknowledge is synchronized internally; 0: acknowledge is already synchronous |
| hold_ack | input | 1 | Hold acknowledge from the external bus owner |
| bus_hreq | output | 1 | Hold request to the external bus owner |
| bus_men | output | 1 | Master enable; high while the block drives the shared bus |
| bus_owned | output | 1 | Ownership flag toward the requester |
| acc_done | output | 1 | Completion strobe for an external access |

## Verification
The assertions check the invariants that must hold on every cycle. Master enable never rises without a prior synchronized acknowledge and never stands without the hold request. Completion is a lone pulse that occurs only under ownership. A low acknowledge during ownership drops both outputs on the next edge. The hold request never rises except for an external address. The scenarios are needed for the rest: the exact latency in each acknowledge mode, the boundary at the limit address, the completion count, continued ownership across back-to-back accesses, and re-requesting after an abort.

// File: rtl/hbm_pkg.sv
// Shared types for the hold bus master.
// Assumes: one-hot-free binary state encoding is acceptable for a small FSM.
package hbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // no external access in flight
        ST_REQ      = 3'd1,  // hold request raised, waiting for acknowledge
        ST_OWN      = 3'd2,  // bus owned, access being timed
        ST_LINGER   = 3'd3,  // bus owned, access finished, deciding to keep or release
        ST_WAIT_LOW = 3'd4   // released after withdrawal, waiting to see acknowledge low
    } hbm_state_e;

endpackage

// File: rtl/hbm_ack_sync.sv
// Acknowledge conditioner: either passes hold acknowledge straight through
// (already synchronous) or through a chain of SYNC_STAGES flops.
// Assumes: async_mode is static while a handshake is in flight.
module hbm_ack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic ack_raw,
    output logic ack_seen
);

    logic [SYNC_STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw acknowledge.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ack_raw;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Pick the synchronized or the direct acknowledge.
    always_comb begin
        ack_seen = async_mode ? chain_q[SYNC_STAGES-1] : ack_raw;
    end

endmodule

// File: rtl/hbm_range_check.sv
// Address classifier: flags a valid request whose address lies above the
// local graphics memory limit. Local memory spans 0 .. limit inclusive.
module hbm_range_check #(
    parameter int AW = 22
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] mem_limit,
    output logic          ext_pending
);

    // External only when strictly above the configured limit.
    always_comb begin
        ext_pending = req_valid && (req_addr > mem_limit);
    end

endmodule

// File: rtl/hbm_ctrl.sv
// Handshake controller: raises the hold request for external accesses,
// enters ownership one clock after the conditioned acknowledge, times each
// access for ACC_CYCLES owned cycles, keeps the bus for back-to-back
// external accesses, and releases at once when the acknowledge drops.
// Assumes: the requester holds its request until the completion strobe.
module hbm_ctrl
    import hbm_pkg::*;
#(
    parameter int ACC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pending,
    input  logic ack_seen,
    output logic hreq,
    output logic men,
    output logic done
);

    localparam int CW = (ACC_CYCLES > 2) ? $clog2(ACC_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(ACC_CYCLES - 1);

    hbm_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_beat;

    // Final owned cycle of the current access.
    always_comb begin
        last_beat = (state_q == ST_OWN) && (cnt_q == LAST);
    end

    // Next-state selection for the handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ext_pending) state_d = ST_REQ;
            ST_REQ: begin
                if (!ext_pending)  state_d = ST_IDLE;
                else if (ack_seen) state_d = ST_OWN;
            end
            ST_OWN: begin
                if (!ack_seen)      state_d = ST_WAIT_LOW;
                else if (last_beat) state_d = ST_LINGER;
            end
            ST_LINGER: begin
                if (!ack_seen)        state_d = ST_WAIT_LOW;
                else if (ext_pending) state_d = ST_OWN;
                else                  state_d = ST_IDLE;
            end
            ST_WAIT_LOW: begin
                if (!ack_seen) state_d = ext_pending ? ST_REQ : ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Owned-cycle counter, cleared whenever an access (re)starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (state_q != ST_OWN) cnt_q <= '0;
        else if (!last_beat)        cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    // Outputs decoded from state; completion needs a live acknowledge.
    always_comb begin
        hreq = (state_q == ST_REQ) || (state_q == ST_OWN) || (state_q == ST_LINGER);
        men  = (state_q == ST_OWN) || (state_q == ST_LINGER);
        done = last_beat && ack_seen;
    end

endmodule

// File: rtl/hold_bus_master.sv
// Top of the hold bus master: classifies the request address, conditions
// the hold acknowledge and runs the ownership handshake.
// Assumes: gfx_top and ack_async are quasi-static configuration.
module hold_bus_master #(
    parameter int AW          = 22,
    parameter int ACC_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] gfx_top,
    input  logic          ack_async,
    input  logic          hold_ack,
    output logic          bus_hreq,
    output logic          bus_men,
    output logic          bus_owned,
    output logic          acc_done
);

    logic ext_pending;
    logic ack_seen;
    logic men_int;

    hbm_range_check #(.AW(AW)) u_range (
        .req_valid   (acc_valid),
        .req_addr    (acc_addr),
        .mem_limit   (gfx_top),
        .ext_pending (ext_pending)
    );

    hbm_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (ack_async),
        .ack_raw    (hold_ack),
        .ack_seen   (ack_seen)
    );

    hbm_ctrl #(.ACC_CYCLES(ACC_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pending (ext_pending),
        .ack_seen    (ack_seen),
        .hreq        (bus_hreq),
        .men         (men_int),
        .done        (acc_done)
    );

    // Master enable and ownership flag share the same condition.
    always_comb begin
        bus_men   = men_int;
        bus_owned = men_int;
    end

endmodule

// File: rtl/hbm_checker.sv
// Cycle invariants of the hold bus master, attached by bind.
module hbm_checker #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic [AW-1:0] acc_addr,
    input logic [AW-1:0] gfx_top,
    input logic          ack_seen,
    input logic          bus_hreq,
    input logic          bus_men,
    input logic          acc_done
);

    assert_hreq_only_external_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hreq) |-> $past(acc_valid && (acc_addr > gfx_top)));

    assert_men_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_men) |-> $past(ack_seen));

    assert_men_needs_hreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_men |-> bus_hreq);

    assert_release_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hreq) |-> !bus_men);

    assert_done_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> bus_men);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    assert_drop_on_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_men && !ack_seen) |=> (!bus_men && !bus_hreq));

endmodule

bind hold_bus_master hbm_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .gfx_top   (gfx_top),
    .ack_seen  (ack_seen),
    .bus_hreq  (bus_hreq),
    .bus_men   (bus_men),
    .acc_done  (acc_done)
);

// File: tb/hold_bus_master_tb.sv
module hold_bus_master_tb;

    localparam int AW  = 22;
    localparam int ACC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [AW-1:0] gfx_top = 22'h0F_FFFF;
    logic          ack_async = 1'b0;
    logic          hold_ack = 1'b0;
    logic          bus_hreq, bus_men, bus_owned, acc_done;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    hold_bus_master #(.AW(AW), .ACC_CYCLES(ACC)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .gfx_top(gfx_top), .ack_async(ack_async), .hold_ack(hold_ack),
        .bus_hreq(bus_hreq), .bus_men(bus_men), .bus_owned(bus_owned),
        .acc_done(acc_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still summarizes.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Wait until completion seen at a negedge; returns cycles waited.
    task automatic wait_done(output int waited);
        waited = 0;
        while (!acc_done && waited < 40) begin
            step(1);
            waited++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 hreq", bus_hreq, 0);
        chk("R1 men", bus_men, 0);
        chk("R1 owned", bus_owned, 0);
        chk("R1 done", acc_done, 0);
    endtask

    task automatic t_local();
        int seen = 0;
        acc_addr = gfx_top;       // boundary: limit itself is local
        acc_valid = 1'b1;
        hold_ack = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (bus_hreq || acc_done) seen++;
        end
        chk("R2 limit address stays local", seen, 0);
        acc_addr = 22'h00_0010;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (bus_hreq || acc_done) seen++;
        end
        chk("R2 low address stays local", seen, 0);
        acc_valid = 1'b0;
        hold_ack = 1'b0;
        step(2);
    endtask

    task automatic t_sync_access();
        int w;
        ack_async = 1'b0;
        acc_addr = gfx_top + 1;
        acc_valid = 1'b1;
        step(1);
        chk("R3 hreq after one edge", bus_hreq, 1);
        chk("R3 men waits for ack", bus_men, 0);
        hold_ack = 1'b1;
        step(1);
        chk("R4 men one edge after ack", bus_men, 1);
        chk("R4 owned flag", bus_owned, 1);
        step(ACC - 2);
        chk("R7 no early done", acc_done, 0);
        step(1);
        chk("R7 done in final owned cycle", acc_done, 1);
        acc_valid = 1'b0;
        step(1);
        chk("R7 done is one cycle", acc_done, 0);
        chk("R9 still owned one edge after", bus_men, 1);
        step(1);
        chk("R9 hreq released", bus_hreq, 0);
        chk("R9 men released", bus_men, 0);
        hold_ack = 1'b0;
        step(2);
        w = 0;
    endtask

    task automatic t_async();
        int w;
        ack_async = 1'b1;
        acc_addr = 22'h3F_FFFF;
        acc_valid = 1'b1;
        step(1);
        chk("R3 hreq async mode", bus_hreq, 1);
        hold_ack = 1'b1;
        step(2);
        chk("R5 men not before sync", bus_men, 0);
        step(1);
        chk("R5 men third edge", bus_men, 1);
        wait_done(w);
        chk("R7 async done seen", acc_done, 1);
        acc_valid = 1'b0;
        step(2);
        chk("R9 async release", bus_hreq, 0);
        hold_ack = 1'b0;
        step(4);
        ack_async = 1'b0;
    endtask

    task automatic t_back2back();
        int gaps = 0;
        int dones = 0;
        acc_addr = gfx_top + 22'h100;
        acc_valid = 1'b1;
        step(1);
        hold_ack = 1'b1;
        for (int i = 0; i < 30 && dones < 2; i++) begin
            step(1);
            if (!bus_hreq) gaps++;
            if (acc_done) begin
                dones++;
                if (dones == 1) acc_addr = gfx_top + 22'h200;
                else acc_valid = 1'b0;
            end
        end
        chk("R8 no hreq gap", gaps, 0);
        chk("R8 both accesses done", dones, 2);
        step(2);
        chk("R9 released after pair", bus_hreq, 0);
        hold_ack = 1'b0;
        step(2);
    endtask

    task automatic t_abort();
        int w;
        int early = 0;
        acc_addr = gfx_top + 22'h40;
        acc_valid = 1'b1;
        step(1);
        hold_ack = 1'b1;
        step(1);
        chk("R4 owned before abort", bus_men, 1);
        step(1);
        hold_ack = 1'b0;
        if (acc_done) early++;
        step(1);
        chk("R10 hreq dropped", bus_hreq, 0);
        chk("R10 men dropped", bus_men, 0);
        chk("R10 no done for aborted", early + acc_done, 0);
        step(1);
        chk("R11 re-request", bus_hreq, 1);
        hold_ack = 1'b1;
        wait_done(w);
        chk("R11 retried access done", acc_done, 1);
        acc_valid = 1'b0;
        step(2);
        hold_ack = 1'b0;
        step(2);
    endtask

    initial begin
        t_reset();
        t_local();
        t_sync_access();
        t_async();
        t_back2back();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule